// File: doc/BRIEF.md
# Pointer Transition Cache with Store Teaching

This block remembers where heap pointers lead. It is indexed by the effective address of a load. When a lookup hits, it returns the address of the heap object that the word at that address pointed to when the block last saw it. A core probes the lookup port at the same time as its first-level data access. On a hit, it can hand the predicted base address to dependent loads at once, and it can start fetching the target object early.

Training comes from retirement. A retiring load that looks like a heap-to-heap pointer may allocate an entry, but only if it missed the last-level cache. Such a load may also correct an entry whose prediction turned out to be stale. A retiring store only refreshes an entry that already exists; it never creates one.

Each entry keeps a short partial tag and a 26-bit address-relative offset instead of a full pointer. Storage stays small, at the price of occasional aliasing between addresses that share index and tag bits.

Top module: `ptr_xition_cache`

## Requirements
- R1: Lookup is combinational. With bits [1:0] as the word offset, the set is ea[OFF+IDX-1:OFF] and the partial tag is the 10 bits just above the set field. A valid way whose tag matches gives hit=1 and pred={ea[31:26], ea[25:0]+offset}; otherwise hit=0 and pred=0.
- R2: An entry stores offset = (value[25:0] − ea[25:0]) mod 2^26. An address that differs from a trained address only in bits above the tag field (bits 31:26 excepted) also hits, and its prediction is rebuilt from its own address.
- R3: A retiring load counts as a pointer load only when ea[31:26] equals value[31:26] and its stack-pointer-source flag is 0. A load that is not a pointer load leaves the cache unchanged.
- R4: A retiring pointer load that misses allocates an entry holding its tag and offset if its L3-miss flag is 1. It allocates nothing if the flag is 0.
- R5: A retiring pointer load that hits, but whose rebuilt prediction differs from the loaded value, rewrites that entry's offset whatever its L3-miss flag. If the prediction equals the loaded value, nothing changes.
- R6: A retiring store whose address hits overwrites that entry's offset with the one computed from the store data and keeps the tag. A store that misses changes nothing.
- R7: Allocation fills the lowest-numbered invalid way of the set first. In a full set it replaces the way named by that set's round-robin pointer, which starts at way 0 and advances by one, wrapping, each time it picks a victim.
- R8: Updates are written at the rising clock edge. A lookup in the same cycle as an update to its set returns the pre-update contents.
- R9: When a store and a load retire in the same cycle, the store is applied and the load's training is dropped.
- R10: Reset (rst_n low) clears every valid bit and returns every round-robin pointer to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | ADDR_W | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_pred | output | ADDR_W | Predicted pointer value |
| cl_valid | input | 1 | A load retires this cycle |
| cl_addr | input | ADDR_W | Retiring load effective address |
| cl_data | input | ADDR_W | Value the load returned |
| cl_l3_miss | input | 1 | Load missed the last-level cache |
| cl_sp_src | input | 1 | Load used the stack pointer as a source |
| st_valid | input | 1 | A store retires this cycle |
| st_addr | input | ADDR_W | Retiring store address |
| st_data | input | ADDR_W | Store data |

## Verification
The bench builds the block with SETS=4 and WAYS=4, keeping the 32-bit address, 10-bit tag and 26-bit offset. Four sets make it quick to fill one set completely and watch the round-robin pointer evict ways in order, then confirm that reset rewinds it. The narrow index also puts set and tag fields at fixed low bit positions, so the bench can build aliasing addresses and same-set conflicts by hand.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_FIX   = 2'd1,
      UPD_ALLOC = 2'd2,
      UPD_STORE = 2'd3
   } upd_kind_e;
endpackage

// File: rtl/pxc_classifier.sv
module pxc_classifier #(
   parameter int ADDR_W = 32,
   parameter int HEAP_W = 6
) (
   input  logic [ADDR_W-1:0] ea,
   input  logic [ADDR_W-1:0] value,
   input  logic              sp_src,
   output logic              is_ptr
);
   if (HEAP_W < 1 || HEAP_W > ADDR_W) begin : g_bad_heap
      $error("pxc_classifier: HEAP_W out of range");
   end

   // heap-to-heap heuristic: same high region, not a stack-relative access
   assign is_ptr = !sp_src && (ea[ADDR_W-1 -: HEAP_W] == value[ADDR_W-1 -: HEAP_W]);
endmodule

// File: rtl/pxc_set_probe.sv
module pxc_set_probe #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 10,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]            way_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [TAG_W-1:0]           probe_tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/pxc_victim.sv
module pxc_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]  way_valid,
   input  logic [WAY_W-1:0] rr_ptr,
   output logic [WAY_W-1:0] victim,
   output logic             set_full
);
   logic             found;
   logic [WAY_W-1:0] first_free;

   always_comb begin
      found      = 1'b0;
      first_free = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !way_valid[w]) begin
            found      = 1'b1;
            first_free = WAY_W'(w);
         end
      end
   end

   assign set_full = !found;
   assign victim   = found ? first_free : rr_ptr;
endmodule

// File: rtl/ptr_xition_cache.sv
module ptr_xition_cache
   import pxc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   parameter int TAG_W      = 10,
   parameter int DIFF_W     = 26,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_pred,
   input  logic              cl_valid,
   input  logic [ADDR_W-1:0] cl_addr,
   input  logic [ADDR_W-1:0] cl_data,
   input  logic              cl_l3_miss,
   input  logic              cl_sp_src,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [ADDR_W-1:0] st_data
);
   localparam int HEAP_W = ADDR_W - DIFF_W;
   localparam int OFF_W  = $clog2(WORD_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("ptr_xition_cache: SETS must be a power of two >= 2");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("ptr_xition_cache: WAYS must be >= 1");
   end
   if (DIFF_W < 1 || HEAP_W < 1) begin : g_bad_diff
      $error("ptr_xition_cache: DIFF_W must leave high heap bits");
   end
   if (OFF_W + IDX_W + TAG_W > ADDR_W) begin : g_bad_fields
      $error("ptr_xition_cache: offset, index and tag exceed address");
   end

   // ---------------- storage ----------------
   logic [SETS-1:0][WAYS-1:0]             valid_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][DIFF_W-1:0] diff_q;
   logic [SETS-1:0][WAY_W-1:0]            rr_q;

   function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
      return a[OFF_W +: IDX_W];
   endfunction

   function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
      return a[OFF_W+IDX_W +: TAG_W];
   endfunction

   function automatic logic [DIFF_W-1:0] diff_of(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] v);
      return v[DIFF_W-1:0] - a[DIFF_W-1:0];
   endfunction

   function automatic logic [ADDR_W-1:0] rebuild(input logic [ADDR_W-1:0] a,
                                                 input logic [DIFF_W-1:0] d);
      return {a[ADDR_W-1:DIFF_W], a[DIFF_W-1:0] + d};
   endfunction

   // ---------------- lookup port ----------------
   logic [IDX_W-1:0] lk_set;
   logic [WAYS-1:0]  lk_hit_vec;
   logic [WAY_W-1:0] lk_way;

   assign lk_set = idx_of(lk_addr);

   pxc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) i_probe_lk (
      .way_valid (valid_q[lk_set]),
      .way_tag   (tag_q[lk_set]),
      .probe_tag (tag_of(lk_addr)),
      .hit_vec   (lk_hit_vec),
      .hit       (lk_hit),
      .hit_way   (lk_way)
   );

   assign lk_pred = lk_hit ? rebuild(lk_addr, diff_q[lk_set][lk_way]) : '0;

   // ---------------- commit-load port ----------------
   logic [IDX_W-1:0]  cl_set;
   logic [WAYS-1:0]   cl_hit_vec;
   logic              cl_hit;
   logic [WAY_W-1:0]  cl_way;
   logic              cl_ptr;
   logic [WAY_W-1:0]  cl_victim;
   logic              cl_set_full;
   logic [ADDR_W-1:0] cl_pred;

   assign cl_set = idx_of(cl_addr);

   pxc_classifier #(.ADDR_W(ADDR_W), .HEAP_W(HEAP_W)) i_class (
      .ea     (cl_addr),
      .value  (cl_data),
      .sp_src (cl_sp_src),
      .is_ptr (cl_ptr)
   );

   pxc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) i_probe_cl (
      .way_valid (valid_q[cl_set]),
      .way_tag   (tag_q[cl_set]),
      .probe_tag (tag_of(cl_addr)),
      .hit_vec   (cl_hit_vec),
      .hit       (cl_hit),
      .hit_way   (cl_way)
   );

   pxc_victim #(.WAYS(WAYS)) i_victim (
      .way_valid (valid_q[cl_set]),
      .rr_ptr    (rr_q[cl_set]),
      .victim    (cl_victim),
      .set_full  (cl_set_full)
   );

   assign cl_pred = rebuild(cl_addr, diff_q[cl_set][cl_way]);

   // ---------------- commit-store port ----------------
   logic [IDX_W-1:0] st_set;
   logic [WAYS-1:0]  st_hit_vec;
   logic             st_hit;
   logic [WAY_W-1:0] st_way;
   logic             unused_st_hi;

   assign st_set       = idx_of(st_addr);
   assign unused_st_hi = ^{st_addr[ADDR_W-1:DIFF_W], st_hit_vec, cl_hit_vec};

   pxc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) i_probe_st (
      .way_valid (valid_q[st_set]),
      .way_tag   (tag_q[st_set]),
      .probe_tag (tag_of(st_addr)),
      .hit_vec   (st_hit_vec),
      .hit       (st_hit),
      .hit_way   (st_way)
   );

   // ---------------- update select: store first, then load ----------------
   upd_kind_e         upd_kind;
   logic [IDX_W-1:0]  w_set;
   logic [WAY_W-1:0]  w_way;
   logic [TAG_W-1:0]  w_tag;
   logic [DIFF_W-1:0] w_diff;

   always_comb begin
      upd_kind = UPD_NONE;
      w_set    = cl_set;
      w_way    = cl_way;
      w_tag    = tag_of(cl_addr);
      w_diff   = diff_of(cl_addr, cl_data);
      if (st_valid) begin
         w_set  = st_set;
         w_way  = st_way;
         w_tag  = tag_of(st_addr);
         w_diff = diff_of(st_addr, st_data);
         if (st_hit) upd_kind = UPD_STORE;
      end else if (cl_valid && cl_ptr) begin
         if (cl_hit) begin
            if (cl_pred != cl_data) upd_kind = UPD_FIX;
         end else if (cl_l3_miss) begin
            upd_kind = UPD_ALLOC;
            w_way    = cl_victim;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         rr_q    <= '0;
      end else if (upd_kind == UPD_ALLOC) begin
         valid_q[w_set][w_way] <= 1'b1;
         if (cl_set_full) begin
            rr_q[w_set] <= (rr_q[w_set] == WAY_W'(WAYS-1)) ? '0 : rr_q[w_set] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (upd_kind == UPD_ALLOC) tag_q[w_set][w_way] <= w_tag;
      if (upd_kind != UPD_NONE)  diff_q[w_set][w_way] <= w_diff;
   end

   // ---------------- assertions ----------------
   AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec)); // R4

   AST_STORE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |=> $countones(valid_q) == $past($countones(valid_q))); // R6

   AST_ONE_FILL_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(valid_q) <= $past($countones(valid_q)) + 1); // R7

   AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_kind == UPD_ALLOC && !(&valid_q[cl_set])) |-> !valid_q[cl_set][cl_victim]); // R7

   AST_STORE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_hit) |=> $countones(valid_q) == $past($countones(valid_q))); // R9
endmodule

// File: tb/test_ptr_xition_cache.sv
`timescale 1ns/1ps
module test_ptr_xition_cache;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_hit;
   logic [AW-1:0] lk_pred;
   logic          cl_valid = 1'b0;
   logic [AW-1:0] cl_addr = '0;
   logic [AW-1:0] cl_data = '0;
   logic          cl_l3_miss = 1'b0;
   logic          cl_sp_src = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [AW-1:0] st_data = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ptr_xition_cache #(.ADDR_W(32), .SETS(4), .WAYS(4), .TAG_W(10), .DIFF_W(26),
                      .WORD_BYTES(4)) i_ptr_xition_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_pred(lk_pred),
      .cl_valid(cl_valid), .cl_addr(cl_addr), .cl_data(cl_data),
      .cl_l3_miss(cl_l3_miss), .cl_sp_src(cl_sp_src),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
   );

   // set field bits [3:2], tag field bits [13:4]
   function automatic logic [AW-1:0] mk(input int set, input int tag);
      return 32'h1000_0000 | (32'(tag) << 4) | (32'(set) << 2);
   endfunction

   // expected prediction at address a for an entry trained at t with value v
   function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input logic [AW-1:0] t,
                                           input logic [AW-1:0] v);
      logic [25:0] d;
      d = v[25:0] - t[25:0];
      return {a[31:26], a[25:0] + d};
   endfunction

   task automatic look(input logic [AW-1:0] a, input bit eh, input logic [AW-1:0] ep,
                       input string req);
      lk_addr = a;
      #1;
      checks++;
      if (lk_hit !== eh || lk_pred !== (eh ? ep : '0)) begin
         errors++;
         $display("FAIL %s addr=%h hit=%0b pred=%h expected hit=%0b pred=%h",
                  req, a, lk_hit, lk_pred, eh, eh ? ep : '0);
      end
   endtask

   task automatic do_load(input logic [AW-1:0] a, input logic [AW-1:0] d,
                          input bit l3, input bit sp);
      @(negedge clk);
      cl_valid = 1; cl_addr = a; cl_data = d; cl_l3_miss = l3; cl_sp_src = sp;
      @(posedge clk); #1;
      cl_valid = 0; cl_l3_miss = 0; cl_sp_src = 0;
   endtask

   task automatic do_store(input logic [AW-1:0] a, input logic [AW-1:0] d);
      @(negedge clk);
      st_valid = 1; st_addr = a; st_data = d;
      @(posedge clk); #1;
      st_valid = 0;
   endtask

   task automatic t_reset();
      look(mk(0, 1), 0, 0, "R10 empty after reset");
      look(mk(3, 9), 0, 0, "R10 empty after reset");
   endtask

   task automatic t_alloc();
      logic [AW-1:0] a = mk(1, 5);
      logic [AW-1:0] d = 32'h1234_5678;
      logic [AW-1:0] al;
      do_load(a, d, 1, 0);
      look(a, 1, d, "R4 allocate on L3 miss / R1 prediction");
      al = a ^ 32'h0010_0000;
      look(al, 1, model(al, a, d), "R2 partial-tag alias rebuilt from own address");
   endtask

   task automatic t_filters();
      do_load(mk(2, 7), 32'h1000_4000, 0, 0);
      look(mk(2, 7), 0, 0, "R4 no allocate without L3 miss");
      do_load(mk(2, 8), 32'h1000_4000, 1, 1);
      look(mk(2, 8), 0, 0, "R3 stack-pointer source never allocates");
      do_load(mk(2, 9), 32'h8000_4000, 1, 0);
      look(mk(2, 9), 0, 0, "R3 high bits differ, not a pointer");
   endtask

   task automatic t_correct_and_store();
      logic [AW-1:0] a = mk(1, 5);
      do_load(a, 32'h1300_0040, 0, 0);
      look(a, 1, 32'h1300_0040, "R5 mismatch rewrites entry without L3 miss");
      do_load(a, 32'h0300_0040, 0, 0);
      look(a, 1, 32'h1300_0040, "R3 non-pointer hit leaves entry unchanged");
      do_store(mk(3, 9), 32'h1000_0100);
      look(mk(3, 9), 0, 0, "R6 store miss allocates nothing");
      do_store(a, 32'h1100_0000);
      look(a, 1, 32'h1100_0000, "R6 store hit overwrites entry");
   endtask

   task automatic t_replace();
      for (int t = 1; t <= 4; t++) do_load(mk(0, t), 32'h1000_1000 + 32'(t * 16), 1, 0);
      for (int t = 1; t <= 4; t++) look(mk(0, t), 1, 32'h1000_1000 + 32'(t * 16), "R7 free ways filled");
      do_load(mk(0, 5), 32'h1000_1050, 1, 0);
      look(mk(0, 1), 0, 0, "R7 first victim is way 0");
      look(mk(0, 2), 1, 32'h1000_1020, "R7 way 1 kept");
      look(mk(0, 5), 1, 32'h1000_1050, "R7 new entry present");
      do_load(mk(0, 6), 32'h1000_1060, 1, 0);
      look(mk(0, 2), 0, 0, "R7 round-robin advanced to way 1");
      look(mk(0, 3), 1, 32'h1000_1030, "R7 way 2 kept");
   endtask

   task automatic t_same_cycle();
      logic [AW-1:0] c = mk(3, 11);
      @(negedge clk);
      cl_valid = 1; cl_addr = c; cl_data = 32'h1000_7000; cl_l3_miss = 1;
      look(c, 0, 0, "R8 lookup sees old contents in update cycle");
      @(posedge clk); #1;
      cl_valid = 0; cl_l3_miss = 0;
      look(c, 1, 32'h1000_7000, "R8 update visible after edge");
   endtask

   task automatic t_store_wins();
      logic [AW-1:0] e = mk(1, 20);
      logic [AW-1:0] f = mk(2, 21);
      do_load(e, 32'h1000_8000, 1, 0);
      @(negedge clk);
      st_valid = 1; st_addr = e; st_data = 32'h1000_9000;
      cl_valid = 1; cl_addr = f; cl_data = 32'h1000_A000; cl_l3_miss = 1;
      @(posedge clk); #1;
      st_valid = 0; cl_valid = 0; cl_l3_miss = 0;
      look(e, 1, 32'h1000_9000, "R9 store applied");
      look(f, 0, 0, "R9 simultaneous load dropped");
   endtask

   task automatic t_reset_mid();
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      look(mk(1, 20), 0, 0, "R10 reset clears valid");
      look(mk(0, 3), 0, 0, "R10 reset clears valid");
      for (int t = 1; t <= 5; t++) do_load(mk(0, t), 32'h1000_2000 + 32'(t * 16), 1, 0);
      look(mk(0, 1), 0, 0, "R10 round-robin back at way 0");
      look(mk(0, 3), 1, 32'h1000_2030, "R10 way 2 kept after reset");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      t_reset();
      t_alloc();
      t_filters();
      t_correct_and_store();
      t_replace();
      t_same_cycle();
      t_store_wins();
      t_reset_mid();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule